// File: doc/BRIEF.md
# Sixteen-Channel Walsh Code Spreader

This block turns one stream of baseband data from a host processor into sixteen parallel spread-spectrum channels. The host supplies one 16-bit word per symbol period. Bit `ch` of that word becomes the data bit of channel `ch` for one symbol. Each channel is then spread by its own 16-chip Walsh–Hadamard row, so the sixteen outputs are mutually orthogonal and can be summed after up-conversion without interfering with each other. In the chip stream, a code or data value of 0 stands for +1 and a value of 1 stands for −1. A chip is therefore the XOR of the code bit and the data bit.

The host is paced by an interrupt request line. Written words go into a two-slot ping-pong store. The request is raised whenever the spreader moves a word out of the store into its symbol register. It is dropped by the next accepted host write. Chips advance once every `CHIP_CYCLES` clocks, which is derived from the sample clock. A new symbol is taken only when the chip counter wraps from 15 to 0. The sixteen outputs leave as four groups of four lanes, one group per downstream up-converter. Each lane has its own one-cycle valid strobe per chip.

A small sequencer controls symbol timing. It has three states:
- `SEQ_IDLE`: nothing transmitted since reset.
- `SEQ_RUN`: transmitting host data.
- `SEQ_STARVED`: transmitting zero data after an underrun.

Its transitions are:
- start (`SEQ_IDLE`→`SEQ_RUN`, when the first word is available).
- refill (`SEQ_RUN`/`SEQ_STARVED`→`SEQ_RUN`, at a symbol boundary with a word available).
- starve (`SEQ_RUN`/`SEQ_STARVED`→`SEQ_STARVED`, at a symbol boundary with no word).

Top module: `dsss_spreader`

## Requirements
- R1: After reset, `host_irq` is 1, `underrun` is 0, and every chip output and every valid strobe is 0.
- R2: A host write that is accepted clears `host_irq` on the next clock. The transfer of a word into the symbol register sets `host_irq` on the next clock, and this takes priority over a write in the same cycle. A write that is dropped leaves `host_irq` unchanged.
- R3: A write while both ping-pong slots hold unsent words is dropped. The word is never transmitted.
- R4: Accepted words are transmitted in write order, one word per symbol. Bit `ch` of the word (bit 0 = channel 0) is the data bit of channel `ch` for all 16 chips of that symbol.
- R5: Chip `k` (k = 0..15, sent in increasing order) of channel `ch` equals parity(`ch` AND `k`) XOR data bit `ch`. The value 1 denotes −1.
- R6: While transmitting, all sixteen valid strobes pulse together for exactly one cycle every `CHIP_CYCLES` clocks (default 4). In `SEQ_IDLE` no strobe is raised.
- R7: Once transmission has started, consecutive symbols follow with no gap in the chip cadence. A new word is taken only at the boundary after chip 15.
- R8: If no word is available at a symbol boundary, the next symbol carries all-zero data, so each channel sends its bare Walsh row. `underrun` then rises and stays at 1 until reset.
- R9: A word written while the block sends a zero-data symbol is transmitted as the very next symbol.
- R10: Channel `4*g + i` appears on lane `i` of group `g` (`g0_*` to `g3_*`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one word per cycle when high |
| host_data | input | 16 | Host data word, one bit per channel |
| host_irq | output | 1 | Request to the host for more data |
| underrun | output | 1 | Sticky flag: a symbol boundary found no data |
| g0_chip | output | 4 | Chips of channels 0–3 |
| g0_vld | output | 4 | Chip strobes of channels 0–3 |
| g1_chip | output | 4 | Chips of channels 4–7 |
| g1_vld | output | 4 | Chip strobes of channels 4–7 |
| g2_chip | output | 4 | Chips of channels 8–11 |
| g2_vld | output | 4 | Chip strobes of channels 8–11 |
| g3_chip | output | 4 | Chips of channels 12–15 |
| g3_vld | output | 4 | Chip strobes of channels 12–15 |

## Verification
The properties assume that `CHIP_CYCLES` is at least 2, so that a strobe can be followed by a quiet cycle. They also assume the host holds `host_wr` for whole clock cycles with stable data. The stimulus drives every write at the falling edge and keeps it for a full cycle. It deliberately issues one write into a full store, and it lets the store run dry once to reach the underrun path. All other writes are placed inside a symbol, well before the boundary that should consume them.

// File: rtl/dsss_spreader_pkg.sv
`timescale 1ns/1ps
package dsss_spreader_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_RUN     = 2'd1,
        SEQ_STARVED = 2'd2
    } seq_state_t;

    // Sylvester Walsh-Hadamard entry: 1 means -1.
    function automatic logic walsh_bit(input int unsigned row, input int unsigned col);
        logic [31:0] both;
        both = 32'(row & col);
        return ^both;
    endfunction

endpackage

// File: rtl/dsss_word_buffer.sv
`timescale 1ns/1ps
module dsss_word_buffer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         avail,
    output logic [W-1:0] head,
    output logic         wr_acc,
    output logic         irq,
    output logic [1:0]   occ
);

    logic [W-1:0] slot [2];
    logic [1:0]   full;
    logic         wp;
    logic         rp;

    assign wr_acc = wr_en && !full[wp];
    assign avail  = full[rp];
    assign head   = slot[rp];
    assign occ    = {1'b0, full[0]} + {1'b0, full[1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= '0;
            wp   <= 1'b0;
            rp   <= 1'b0;
        end else begin
            if (wr_acc) begin
                full[wp] <= 1'b1;
                wp       <= ~wp;
            end
            if (take) begin
                full[rp] <= 1'b0;
                rp       <= ~rp;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_acc) begin
            slot[wp] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b1;
        end else if (take) begin
            irq <= 1'b1;
        end else if (wr_acc) begin
            irq <= 1'b0;
        end
    end

endmodule

// File: rtl/dsss_sequencer.sv
`timescale 1ns/1ps
module dsss_sequencer
    import dsss_spreader_pkg::*;
#(
    parameter int NCH         = 16,
    parameter int CHIP_CYCLES = 4,
    localparam int LW = $clog2(NCH),
    localparam int DW = (CHIP_CYCLES > 1) ? $clog2(CHIP_CYCLES) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           avail,
    input  logic [NCH-1:0] head,
    output logic           take,
    output logic           emit,
    output logic [NCH-1:0] sym,
    output logic [LW-1:0]  chip_idx,
    output seq_state_t     state,
    output logic           underrun
);

    localparam logic [DW-1:0] DLAST = DW'(CHIP_CYCLES - 1);
    localparam logic [LW-1:0] CLAST = LW'(NCH - 1);

    seq_state_t    nxt;
    logic [DW-1:0] dcnt;
    logic          chip_end;
    logic          sym_end;

    assign chip_end = (dcnt == DLAST);
    assign sym_end  = chip_end && (chip_idx == CLAST);
    assign emit     = (state != SEQ_IDLE) && (dcnt == '0);

    always_comb begin
        nxt  = state;
        take = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                if (avail) begin
                    take = 1'b1;
                    nxt  = SEQ_RUN;
                end
            end
            SEQ_RUN, SEQ_STARVED: begin
                if (sym_end) begin
                    if (avail) begin
                        take = 1'b1;
                        nxt  = SEQ_RUN;
                    end else begin
                        nxt  = SEQ_STARVED;
                    end
                end
            end
            default: nxt = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt     <= '0;
            chip_idx <= '0;
            sym      <= '0;
            underrun <= 1'b0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    dcnt     <= '0;
                    chip_idx <= '0;
                    if (take) begin
                        sym <= head;
                    end
                end
                SEQ_RUN, SEQ_STARVED: begin
                    if (chip_end) begin
                        dcnt     <= '0;
                        chip_idx <= chip_idx + 1'b1;
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                    if (sym_end) begin
                        if (take) begin
                            sym <= head;
                        end else begin
                            sym      <= '0;
                            underrun <= 1'b1;
                        end
                    end
                end
                default: begin
                    dcnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/dsss_chip_mapper.sv
`timescale 1ns/1ps
module dsss_chip_mapper
    import dsss_spreader_pkg::*;
#(
    parameter int NCH = 16,
    localparam int LW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           emit,
    input  logic [NCH-1:0] sym,
    input  logic [LW-1:0]  chip_idx,
    output logic [NCH-1:0] chips,
    output logic [NCH-1:0] vld
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        logic code;
        assign code = walsh_bit(ch, 32'(chip_idx));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chips[ch] <= 1'b0;
                vld[ch]   <= 1'b0;
            end else begin
                vld[ch] <= emit;
                if (emit) begin
                    chips[ch] <= code ^ sym[ch];
                end
            end
        end
    end

endmodule

// File: rtl/dsss_spreader.sv
`timescale 1ns/1ps
module dsss_spreader
    import dsss_spreader_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int CHIP_CYCLES = 4,
    localparam int NCH = 4 * LANES,
    localparam int LW  = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [NCH-1:0]   host_data,
    output logic             host_irq,
    output logic             underrun,
    output logic [LANES-1:0] g0_chip,
    output logic [LANES-1:0] g0_vld,
    output logic [LANES-1:0] g1_chip,
    output logic [LANES-1:0] g1_vld,
    output logic [LANES-1:0] g2_chip,
    output logic [LANES-1:0] g2_vld,
    output logic [LANES-1:0] g3_chip,
    output logic [LANES-1:0] g3_vld
);

    logic           avail;
    logic [NCH-1:0] head;
    logic           take;
    logic           wr_acc;
    logic [1:0]     occ;
    logic           emit;
    logic [NCH-1:0] sym;
    logic [LW-1:0]  chip_idx;
    seq_state_t     state;
    logic [NCH-1:0] chip_all;
    logic [NCH-1:0] vld_all;

    dsss_word_buffer #(.W(NCH)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr),
        .wr_data (host_data),
        .take    (take),
        .avail   (avail),
        .head    (head),
        .wr_acc  (wr_acc),
        .irq     (host_irq),
        .occ     (occ)
    );

    dsss_sequencer #(.NCH(NCH), .CHIP_CYCLES(CHIP_CYCLES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .avail    (avail),
        .head     (head),
        .take     (take),
        .emit     (emit),
        .sym      (sym),
        .chip_idx (chip_idx),
        .state    (state),
        .underrun (underrun)
    );

    dsss_chip_mapper #(.NCH(NCH)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .emit     (emit),
        .sym      (sym),
        .chip_idx (chip_idx),
        .chips    (chip_all),
        .vld      (vld_all)
    );

    assign g0_chip = chip_all[0*LANES +: LANES];
    assign g1_chip = chip_all[1*LANES +: LANES];
    assign g2_chip = chip_all[2*LANES +: LANES];
    assign g3_chip = chip_all[3*LANES +: LANES];
    assign g0_vld  = vld_all[0*LANES +: LANES];
    assign g1_vld  = vld_all[1*LANES +: LANES];
    assign g2_vld  = vld_all[2*LANES +: LANES];
    assign g3_vld  = vld_all[3*LANES +: LANES];

endmodule

// File: rtl/dsss_spreader_chk.sv
`timescale 1ns/1ps
module dsss_spreader_chk
    import dsss_spreader_pkg::*;
#(
    parameter int NCH         = 16,
    parameter int CHIP_CYCLES = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           host_irq,
    input logic           underrun,
    input logic [NCH-1:0] vld_all,
    input logic           take,
    input logic           wr_acc,
    input logic [1:0]     occ,
    input seq_state_t     state
);

    // R2: moving a word into the symbol register raises the request
    p_irq_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> host_irq);

    // R2: an accepted write without a transfer drops the request
    p_irq_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && !take) |=> !host_irq);

    // R3: a full store stays full until a word is taken out
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == 2'd2 && !take) |=> (occ == 2'd2));

    // R3: the store never holds more than two words
    p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= 2'd2);

    // R6: all lanes strobe together
    p_vld_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_all == '0) || (vld_all == '1));

    // R6: no strobe is produced from the idle state
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE) |=> (vld_all == '0));

    if (CHIP_CYCLES > 1) begin : g_single
        // R6: a strobe lasts exactly one cycle
        p_vld_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
            vld_all[0] |=> !vld_all[0]);
    end

    // R8: the underrun flag is sticky
    p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    // R8: the starved state is only reached through an underrun
    p_starved_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_STARVED) |-> underrun);

endmodule

bind dsss_spreader dsss_spreader_chk #(.NCH(NCH), .CHIP_CYCLES(CHIP_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_irq (host_irq),
    .underrun (underrun),
    .vld_all  (vld_all),
    .take     (take),
    .wr_acc   (wr_acc),
    .occ      (occ),
    .state    (state)
);

// File: tb/dsss_spreader_test.sv
`timescale 1ns/1ps
module dsss_spreader_test;

    localparam int LANES = 4;
    localparam int CC    = 4;
    localparam int NCH   = 4 * LANES;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           host_wr = 1'b0;
    logic [NCH-1:0] host_data = '0;
    logic           host_irq;
    logic           underrun;
    logic [LANES-1:0] g0_chip, g0_vld, g1_chip, g1_vld, g2_chip, g2_vld, g3_chip, g3_vld;

    dsss_spreader #(.LANES(LANES), .CHIP_CYCLES(CC)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_data(host_data),
        .host_irq(host_irq), .underrun(underrun),
        .g0_chip(g0_chip), .g0_vld(g0_vld), .g1_chip(g1_chip), .g1_vld(g1_vld),
        .g2_chip(g2_chip), .g2_vld(g2_vld), .g3_chip(g3_chip), .g3_vld(g3_vld)
    );

    always #2.5 clk = ~clk;

    // R10: channel 4*g+i sits on lane i of group g
    wire [NCH-1:0] chips = {g3_chip, g2_chip, g1_chip, g0_chip};
    wire [NCH-1:0] vlds  = {g3_vld, g2_vld, g1_vld, g0_vld};

    int     total = 0;
    int     bad = 0;
    longint cyc = 0;
    longint last_vld = 0;
    bit     done = 1'b0;
    logic [NCH-1:0] rows [NCH];
    logic   irq_seen [4];
    int     gap_bad;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Collect one symbol; optionally write words right after its first chip.
    task automatic grab(input int n_inj, input logic [NCH-1:0] w0,
                        input logic [NCH-1:0] w1, input logic [NCH-1:0] w2);
        gap_bad = 0;
        for (int k = 0; k < NCH; k++) begin
            do @(negedge clk); while (!vlds[0]);
            rows[k] = chips;
            if (vlds != '1) gap_bad++;
            if (last_vld != 0 && (cyc - last_vld) != CC) gap_bad++;
            last_vld = cyc;
            if (k == 0) begin
                irq_seen[0] = host_irq;
                for (int j = 0; j < n_inj; j++) begin
                    host_wr   = 1'b1;
                    host_data = (j == 0) ? w0 : (j == 1) ? w1 : w2;
                    @(negedge clk);
                    irq_seen[j+1] = host_irq;
                end
                host_wr = 1'b0;
            end
        end
    endtask

    task automatic check_sym(input logic [NCH-1:0] w, input string req, input string what);
        int errs = 0;
        logic [NCH-1:0] first_act = '0;
        logic [NCH-1:0] first_exp = '0;
        for (int k = 0; k < NCH; k++) begin
            logic [NCH-1:0] exp;
            for (int ch = 0; ch < NCH; ch++) begin
                logic [3:0] m;
                m = 4'(ch) & 4'(k);
                exp[ch] = (^m) ^ w[ch];
            end
            if (rows[k] !== exp) begin
                if (errs == 0) begin
                    first_act = rows[k];
                    first_exp = exp;
                end
                errs++;
            end
        end
        check(errs == 0, req, what, first_act, first_exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(host_irq === 1'b1, "R1", "irq in reset", host_irq, 1);
        check(underrun === 1'b0, "R1", "underrun in reset", underrun, 0);
        check(vlds === '0, "R1", "strobes in reset", vlds, 0);
        check(chips === '0, "R1", "chips in reset", chips, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(vlds === '0 && host_irq === 1'b1, "R6", "idle stays quiet",
              {vlds, 3'b000, host_irq}, 1);
    endtask

    task automatic t_first_symbol();
        @(negedge clk);
        host_wr = 1'b1;
        host_data = 16'hA5C3;
        @(negedge clk);
        host_wr = 1'b0;
        check(host_irq === 1'b0, "R2", "irq cleared by write", host_irq, 0);
        // B and C fill the store, D hits a full store and must be dropped
        grab(3, 16'hFFFF, 16'h1234, 16'hBEEF);
        check(irq_seen[0] === 1'b1, "R2", "irq set on transfer", irq_seen[0], 1);
        check(irq_seen[1] === 1'b0, "R2", "irq cleared by B", irq_seen[1], 0);
        check(irq_seen[3] === 1'b0, "R3", "dropped write keeps irq", irq_seen[3], 0);
        check_sym(16'hA5C3, "R5", "first symbol chips");
        check(gap_bad == 0, "R6", "strobe cadence first symbol", gap_bad, 0);
    endtask

    task automatic t_order();
        grab(0, '0, '0, '0);
        check_sym(16'hFFFF, "R4", "second word in order");
        check(gap_bad == 0, "R7", "no gap into second symbol", gap_bad, 0);
        check(host_irq === 1'b1, "R2", "irq after B transfer", host_irq, 1);
        grab(0, '0, '0, '0);
        check_sym(16'h1234, "R4", "third word in order");
        check(gap_bad == 0, "R7", "no gap into third symbol", gap_bad, 0);
        check(underrun === 1'b0, "R8", "no underrun while fed", underrun, 0);
    endtask

    task automatic t_underrun();
        grab(1, 16'h0F0F, '0, '0);
        check_sym('0, "R8", "zero data on underrun");
        check_sym('0, "R3", "dropped word not sent");
        check(underrun === 1'b1, "R8", "underrun raised", underrun, 1);
        check(irq_seen[1] === 1'b0, "R2", "irq cleared while starved", irq_seen[1], 0);
        check(gap_bad == 0, "R7", "cadence kept on underrun", gap_bad, 0);
        grab(0, '0, '0, '0);
        check_sym(16'h0F0F, "R9", "resume with next word");
        check(underrun === 1'b1, "R8", "underrun sticky", underrun, 1);
        check(host_irq === 1'b1, "R2", "irq after resume transfer", host_irq, 1);
        check(gap_bad == 0, "R6", "cadence after resume", gap_bad, 0);
    endtask

    initial begin
        t_reset();
        t_first_symbol();
        t_order();
        t_underrun();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule